// File: doc/BRIEF.md
# Multi-function pad control cell

This block is the control logic behind a single I/O pad that several internal peripherals share. One 32-bit configuration word, written and read over a minimal register bus, decides which of up to eight peripheral functions reaches the pad. The chosen function's output value and output enable go to the pad, and the pad input is returned to that function alone. The same word sets the pad's behaviour when the chip sleeps, where the pull-up and pull-down requests come from, and the drive-strength code passed to the pad cell.

The cell also watches the pad input for edges. The input is first synchronised to the block clock. Rising and falling transitions can be enabled independently. A qualifying transition sets a sticky status bit, which stays set until software sets the clear control. The status, gated by an external per-pad wakeup enable, forms a wakeup request to the chip-level wakeup controller.

Top module: `pad_ctl_cell`

## Requirements
- R1: After synchronous reset the configuration word reads 0x0000_0880. This is function 0, drive code 010 and sleep output enable negated (bit 7 = 1), with edge detection, sleep override and pull select all 0. The edge status is 0.
- R2: Bit 3 and bits 31:16 of the configuration word always read 0, and writing 1 to them changes nothing. Writing 0xFFFF_FFFF reads back 0x0000_FFF7.
- R3: Field bits 2:0 selects function n. pad_out follows fn_out[n] and pad_oe follows fn_oe[n]. fn_in[n] equals pad_in and every other fn_in bit is 0.
- R4: When lp_mode is 1 and bit 9 is 1, pad_oe equals the inverse of bit 7 and pad_out equals bit 8. In every other case the selected function drives the pad.
- R5: With bit 15 at 0, pad_pu and pad_pd follow fn_pu[n] and fn_pd[n] of the selected function. With bit 15 at 1, pad_pu equals bit 14 and pad_pd equals bit 13.
- R6: pad_drv always equals bits 12:10 of the configuration word, unchanged.
- R7: Suppose pad_in is 1 at clock edge k and was 0 at edge k-1. If bit 4 is 1, edge_seen becomes 1 after edge k+2.
- R8: Suppose pad_in is 0 at clock edge k and was 1 at edge k-1. If bit 5 is 1, edge_seen becomes 1 after edge k+2.
- R9: edge_seen is sticky: once set, it stays 1 while bit 6 is 0. While bit 6 is 1, edge_seen is 0 one clock later, and pad edges do not set it.
- R10: wake_req equals edge_seen ANDed with wake_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current configuration word |
| lp_mode | input | 1 | Chip is in low-power mode |
| fn_out | input | NUM_FUNC | Output value from each peripheral function |
| fn_oe | input | NUM_FUNC | Output enable from each function (1 = drive) |
| fn_pu | input | NUM_FUNC | Pull-up request from each function |
| fn_pd | input | NUM_FUNC | Pull-down request from each function |
| fn_in | output | NUM_FUNC | Pad input returned to the selected function |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Value driven to the pad |
| pad_oe | output | 1 | Pad output enable (1 = drive) |
| pad_pu | output | 1 | Pull-up enable to the pad |
| pad_pd | output | 1 | Pull-down enable to the pad |
| pad_drv | output | 3 | Drive-strength and slew code |
| wake_en | input | 1 | Per-pad wakeup enable |
| edge_seen | output | 1 | Sticky edge status |
| wake_req | output | 1 | Wakeup request |

## Verification
On every cycle, the assertions check the following: the reserved bits stay zero, the sleep override controls the pad, the pull source follows bit 15, and the drive code passes straight through. They also check that the edge status holds while not cleared, drops after a clear, and never raises a wakeup request on its own. Other behaviour only the bench's scenarios can show: the two-cycle synchroniser latency before an edge is seen, the exact routing for each of the eight functions, and the per-direction edge enables. It exercises these with pulses under every enable combination, against a reference model that tracks pad input history.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

    localparam int CFG_W  = 32;
    localparam int FSEL_W = 3;
    localparam int DRV_W  = 3;

    typedef struct packed {
        logic [15:0]       rsvd_hi;
        logic              pull_sel;
        logic              pu_en;
        logic              pd_en;
        logic [DRV_W-1:0]  drive;
        logic              lp_sel;
        logic              lp_data;
        logic              lp_oe_n;
        logic              edge_clr;
        logic              fall_en;
        logic              rise_en;
        logic              rsvd3;
        logic [FSEL_W-1:0] func;
    } pad_cfg_t;

    typedef enum logic [DRV_W-1:0] {
        DRV_FAST_1  = 3'd0,
        DRV_FAST_2  = 3'd1,
        DRV_FAST_3  = 3'd2,
        DRV_FAST_4  = 3'd3,
        DRV_SLOW_6  = 3'd4,
        DRV_FAST_6  = 3'd5,
        DRV_SLOW_10 = 3'd6,
        DRV_FAST_10 = 3'd7
    } drv_code_t;

    typedef struct packed {
        logic val;
        logic oe;
    } pad_drive_t;

    typedef struct packed {
        logic up;
        logic down;
    } pad_pull_t;

    localparam logic [CFG_W-1:0] CFG_WMASK = 32'h0000_FFF7;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0880;

    function automatic pad_cfg_t cfg_sanitize(input logic [CFG_W-1:0] raw);
        return pad_cfg_t'(raw & CFG_WMASK);
    endfunction

    function automatic pad_drive_t pick_drive(input logic lp, input pad_cfg_t c,
                                              input pad_drive_t fn);
        pad_drive_t r;
        if (lp && c.lp_sel) begin
            r.val = c.lp_data;
            r.oe  = ~c.lp_oe_n;
        end else begin
            r = fn;
        end
        return r;
    endfunction

    function automatic pad_pull_t pick_pull(input pad_cfg_t c, input pad_pull_t fn);
        pad_pull_t r;
        if (c.pull_sel) begin
            r.up   = c.pu_en;
            r.down = c.pd_en;
        end else begin
            r = fn;
        end
        return r;
    endfunction

endpackage

// File: rtl/pad_cfg_reg.sv
module pad_cfg_reg
    import pad_mux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output pad_cfg_t         cfg
);

    pad_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= pad_cfg_t'(CFG_RESET);
        end else if (we) begin
            cfg_q <= cfg_sanitize(wdata);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pad_func_mux.sv
module pad_func_mux
    import pad_mux_pkg::*;
#(
    parameter int NUM_FUNC = 8
) (
    input  pad_cfg_t            cfg,
    input  logic                lp_mode,
    input  logic [NUM_FUNC-1:0] fn_out,
    input  logic [NUM_FUNC-1:0] fn_oe,
    input  logic [NUM_FUNC-1:0] fn_pu,
    input  logic [NUM_FUNC-1:0] fn_pd,
    output logic [NUM_FUNC-1:0] fn_in,
    input  logic                pad_in,
    output pad_drive_t          drive,
    output pad_pull_t           pull
);

    logic [NUM_FUNC-1:0] sel_oh;
    pad_drive_t          fn_drive;
    pad_pull_t           fn_pull;

    for (genvar g = 0; g < NUM_FUNC; g++) begin : g_sel
        assign sel_oh[g] = (cfg.func == FSEL_W'(g));
        assign fn_in[g]  = sel_oh[g] & pad_in;
    end

    always_comb begin
        fn_drive.val = |(fn_out & sel_oh);
        fn_drive.oe  = |(fn_oe & sel_oh);
        fn_pull.up   = |(fn_pu & sel_oh);
        fn_pull.down = |(fn_pd & sel_oh);
        drive        = pick_drive(lp_mode, cfg, fn_drive);
        pull         = pick_pull(cfg, fn_pull);
    end

endmodule

// File: rtl/pad_edge_det.sv
module pad_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_in,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr,
    output logic seen
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   seen_q;
    logic                   level;
    logic                   hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pad_in};
            prev_q <= level;
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    always_comb begin
        hit = (rise_en & level & ~prev_q) | (fall_en & ~level & prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
        end else if (clr) begin
            seen_q <= 1'b0;
        end else if (hit) begin
            seen_q <= 1'b1;
        end
    end

    assign seen = seen_q;

endmodule

// File: rtl/pad_ctl_cell.sv
module pad_ctl_cell
    import pad_mux_pkg::*;
#(
    parameter int NUM_FUNC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic                lp_mode,
    input  logic [NUM_FUNC-1:0] fn_out,
    input  logic [NUM_FUNC-1:0] fn_oe,
    input  logic [NUM_FUNC-1:0] fn_pu,
    input  logic [NUM_FUNC-1:0] fn_pd,
    output logic [NUM_FUNC-1:0] fn_in,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                pad_pu,
    output logic                pad_pd,
    output logic [DRV_W-1:0]    pad_drv,
    input  logic                wake_en,
    output logic                edge_seen,
    output logic                wake_req
);

    pad_cfg_t   cfg;
    pad_drive_t drive;
    pad_pull_t  pull;
    drv_code_t  drv_code;

    pad_cfg_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    pad_func_mux #(.NUM_FUNC(NUM_FUNC)) u_mux (
        .cfg     (cfg),
        .lp_mode (lp_mode),
        .fn_out  (fn_out),
        .fn_oe   (fn_oe),
        .fn_pu   (fn_pu),
        .fn_pd   (fn_pd),
        .fn_in   (fn_in),
        .pad_in  (pad_in),
        .drive   (drive),
        .pull    (pull)
    );

    pad_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .rise_en (cfg.rise_en),
        .fall_en (cfg.fall_en),
        .clr     (cfg.edge_clr),
        .seen    (edge_seen)
    );

    assign drv_code  = drv_code_t'(cfg.drive);
    assign cfg_rdata = CFG_W'(cfg);
    assign pad_out   = drive.val;
    assign pad_oe    = drive.oe;
    assign pad_pu    = pull.up;
    assign pad_pd    = pull.down;
    assign pad_drv   = drv_code;
    assign wake_req  = edge_seen & wake_en;

endmodule

// File: rtl/pad_ctl_cell_chk.sv
module pad_ctl_cell_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cfg_rdata,
    input logic        lp_mode,
    input logic        pad_out,
    input logic        pad_oe,
    input logic        pad_pu,
    input logic        pad_pd,
    input logic [2:0]  pad_drv,
    input logic        edge_seen,
    input logic        wake_req
);

    p_reset_value_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_rdata == 32'h0000_0880 && !edge_seen));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[3] == 1'b0 && cfg_rdata[31:16] == 16'h0));

    p_sleep_override_r4: assert property (@(posedge clk) disable iff (rst)
        (lp_mode && cfg_rdata[9]) |-> (pad_oe == !cfg_rdata[7] && pad_out == cfg_rdata[8]));

    p_pull_direct_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[15] |-> (pad_pu == cfg_rdata[14] && pad_pd == cfg_rdata[13]));

    p_drive_pass_r6: assert property (@(posedge clk) disable iff (rst)
        pad_drv == cfg_rdata[12:10]);

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (edge_seen && !cfg_rdata[6]) |=> edge_seen);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6] |=> !edge_seen);

    p_wake_gated_r10: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> edge_seen);

endmodule

bind pad_ctl_cell pad_ctl_cell_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_rdata (cfg_rdata),
    .lp_mode   (lp_mode),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_drv   (pad_drv),
    .edge_seen (edge_seen),
    .wake_req  (wake_req)
);

// File: tb/pad_ctl_cell_tb_top.sv
module pad_ctl_cell_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lp_mode = 1'b0;
    logic [7:0]  fn_out = '0, fn_oe = '0, fn_pu = '0, fn_pd = '0;
    logic [7:0]  fn_in;
    logic        pad_in = 1'b0;
    logic        pad_out, pad_oe, pad_pu, pad_pd;
    logic [2:0]  pad_drv;
    logic        wake_en = 1'b0;
    logic        edge_seen, wake_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit comparing = 1'b0;
    bit done = 1'b0;

    logic [31:0] m_cfg;
    logic        m_stat;
    logic        hist [4];

    always #5 clk = ~clk;

    pad_ctl_cell dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .lp_mode(lp_mode), .fn_out(fn_out),
        .fn_oe(fn_oe), .fn_pu(fn_pu), .fn_pd(fn_pd), .fn_in(fn_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_drv(pad_drv),
        .wake_en(wake_en), .edge_seen(edge_seen), .wake_req(wake_req)
    );

    // Reference model: configuration word, sticky status and input history.
    always @(posedge clk) begin
        if (rst) begin
            m_cfg  = 32'h0000_0880;
            m_stat = 1'b0;
            for (int i = 0; i < 4; i++) hist[i] = 1'b0;
        end else begin
            for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = pad_in;
            // R7 and R8: sample from edge k-2 compared with edge k-3; R9 clear.
            if (m_cfg[6]) m_stat = 1'b0;
            else if ((m_cfg[4] && hist[2] && !hist[3]) ||
                     (m_cfg[5] && !hist[2] && hist[3])) m_stat = 1'b1;
            if (cfg_we) m_cfg = cfg_wdata & 32'h0000_FFF7;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (comparing && !rst) begin
            int n;
            logic e_out, e_oe, e_pu, e_pd;
            n = int'(m_cfg[2:0]);
            e_out = fn_out[n];
            e_oe  = fn_oe[n];
            if (lp_mode && m_cfg[9]) begin
                e_out = m_cfg[8];
                e_oe  = !m_cfg[7];
            end
            e_pu = m_cfg[15] ? m_cfg[14] : fn_pu[n];
            e_pd = m_cfg[15] ? m_cfg[13] : fn_pd[n];
            chk("R2 readback", cfg_rdata, m_cfg);
            chk("R3 fn_in", {24'h0, fn_in}, {24'h0, 8'(pad_in) << n});
            chk("R4 pad_out", {31'h0, pad_out}, {31'h0, e_out});
            chk("R4 pad_oe", {31'h0, pad_oe}, {31'h0, e_oe});
            chk("R5 pad_pu", {31'h0, pad_pu}, {31'h0, e_pu});
            chk("R5 pad_pd", {31'h0, pad_pd}, {31'h0, e_pd});
            chk("R6 pad_drv", {29'h0, pad_drv}, {29'h0, m_cfg[12:10]});
            chk("R9 edge_seen", {31'h0, edge_seen}, {31'h0, m_stat});
            chk("R10 wake_req", {31'h0, wake_req}, {31'h0, m_stat & wake_en});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #3;
            cfg_we = 1'b0;
            fn_out = 8'($urandom);
            fn_oe  = 8'($urandom);
            fn_pu  = 8'($urandom);
            fn_pd  = 8'($urandom);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(posedge clk);
        #3;
        cfg_we = 1'b1;
        cfg_wdata = d;
        tick(1);
    endtask

    task automatic pulse(input int hi);
        pad_in = 1'b1;
        tick(hi);
        pad_in = 1'b0;
        tick(4);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        #2;
        chk("R1 reset word", cfg_rdata, 32'h0000_0880);
        chk("R1 reset status", {31'h0, edge_seen}, 32'h0);
        comparing = 1'b1;

        // R3 every function, R5 pull from function
        for (int f = 0; f < 8; f++) begin
            wr(32'(f) | (32'(f % 8) << 10));
            pad_in = f[0];
            tick(6);
        end
        pad_in = 1'b0;

        // R2 reserved bits
        wr(32'hFFFF_FFFF);
        tick(1);
        #2 chk("R2 all-ones readback", cfg_rdata, 32'h0000_FFF7);
        wr(32'h0000_0000);

        // R4 sleep override with bit 7 = 0 and 1, bit 8 both values
        lp_mode = 1'b1;
        wr(32'h0000_0203); tick(4);
        wr(32'h0000_0383); tick(4);
        wr(32'h0000_0303); tick(4);
        wr(32'h0000_0103); tick(4);
        lp_mode = 1'b0;
        wr(32'h0000_0303); tick(4);

        // R5 direct pull, all combinations
        wr(32'h0000_8000); tick(2);
        wr(32'h0000_A000); tick(2);
        wr(32'h0000_C000); tick(2);
        wr(32'h0000_E000); tick(2);

        // R7 R8 edge enables under all combinations
        wake_en = 1'b1;
        for (int en = 0; en < 4; en++) begin
            wr(32'h0000_0040);
            tick(2);
            wr(32'(en) << 4);
            pulse(3);
            pulse(1);
            wake_en = ~wake_en;
            tick(3);
        end

        // R9 clear suppresses detection while held
        wr(32'h0000_0070);
        pulse(3);
        pulse(2);
        tick(2);
        #2 chk("R9 clear held zero", {31'h0, edge_seen}, 32'h0);
        wr(32'h0000_0030);
        pulse(2);
        #2 chk("R7 status after pulse", {31'h0, edge_seen}, 32'h1);
        tick(10);
        #2 chk("R9 sticky", {31'h0, edge_seen}, 32'h1);
        wake_en = 1'b0;
        tick(1);
        #2 chk("R10 gated off", {31'h0, wake_req}, 32'h0);

        tick(4);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule